// File: doc/BRIEF.md
# Random Word Source Register Front-End

This block is the bus-facing half of a true random number generator. Software sees three 32-bit registers on a simple memory-mapped bus: a control register, a status register and a data register. Entropy words come in on a valid-qualified word input. They are collected in a four-word first-in first-out queue, and each read of the data register takes one word out of that queue.

The block also watches two fault sources. A seed fault stops word collection and sets two status bits: a live bit, which reports the current condition, and a latched bit, which holds until software clears it. The source can drop the live bit on its own through an auto-recovery strobe. Software can also drop it by running a conditioning reset: it sets a control bit, then clears it, then waits until the bit reads back as zero. A clock fault has the same pair of status bits, and a control bit can mask it. Either latched bit, when the interrupt is enabled, drives a single level interrupt output.

Top module: `trng_regfront`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0. Control keeps these fields and reads them back, and reads every other bit as 0: bit 2 (collect enable), bit 3 (interrupt enable), bit 5 (clock-fault mask), bits 19:16 (divider exponent) and bit 30 (conditioning reset).
- R2: An entropy word is taken only when control bit 2 is 1, status bit 2 is 0 and no conditioning reset is active. A word offered at any other time is dropped.
- R3: The queue holds 4 words and returns them oldest first. A word offered while 4 words are held is dropped, even if a data read happens in the same cycle.
- R4: A read at offset 0x08 returns the oldest word and removes it. A read of an empty queue returns 0 and changes nothing. Status bit 0 is 1 exactly when at least one word is held.
- R5: A `seed_fault` pulse while control bit 2 is 1 sets status bit 2 (live) and status bit 6 (latched). A word offered in that same cycle is dropped.
- R6: A `seed_recover` pulse clears status bit 2 and leaves status bit 6 set.
- R7: A status write at offset 0x04 clears bit 5 or bit 6 where the written bit is 0. Where the written bit is 1 it has no effect. All other status bits ignore writes.
- R8: With control bit 5 at 0, status bit 1 follows `clk_fault` one cycle later and sets status bit 5. With control bit 5 at 1, `clk_fault` changes neither bit.
- R9: Control bit 30 reads 1 while it is written 1. Writing it back to 0 starts an internal reset of `CRST_CYCLES` (16) cycles during which it still reads 1. While the bit reads 1, the queue is empty and takes no words. One cycle after it drops, status bit 2 clears and bit 6 stays.
- R10: `irq` is 1 exactly when control bit 3 is 1 and status bit 5 or bit 6 is 1.
- R11: An entropy word and a data read in the same cycle both take effect: the read returns the old head and the new word joins the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset: 0x00 control, 0x04 status, 0x08 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ent_valid | input | 1 | Entropy word offered |
| ent_word | input | 32 | Entropy word |
| seed_fault | input | 1 | Seed fault pulse from the source |
| seed_recover | input | 1 | Source auto-recovery pulse |
| clk_fault | input | 1 | Clock fault level |
| irq | output | 1 | Interrupt level |

## Verification
Two events can land in the same cycle: an entropy word arriving and a data-register read removing the head word. The bench drives both strobes in one cycle in two cases. With one word held, the read must return the old word, and the new word must come out on the next read. With the queue full, the read must still return the head word, and the offered word must be lost. That loss shows up as an empty read after three more reads.

// File: rtl/trng_pkg.sv
package trng_pkg;
    // register offsets (byte addresses)
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_DATA = 8'h08;

    // control bits
    localparam int CB_GEN    = 2;
    localparam int CB_IRQEN  = 3;
    localparam int CB_CKMASK = 5;
    localparam int CB_DIV_LO = 16;
    localparam int DIV_W     = 4;
    localparam int CB_CRST   = 30;

    // status bits
    localparam int SB_READY  = 0;
    localparam int SB_CKLIVE = 1;
    localparam int SB_SDLIVE = 2;
    localparam int SB_CKLAT  = 5;
    localparam int SB_SDLAT  = 6;

    typedef struct packed {
        logic             gen_en;
        logic             irq_en;
        logic             ck_mask;
        logic [DIV_W-1:0] div_exp;
        logic             crst_req;
        logic             sd_live;
        logic             sd_lat;
        logic             ck_live;
        logic             ck_lat;
    } regs_t;
endpackage

// File: rtl/trng_wfifo.sv
module trng_wfifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fst_t;

    fst_t q, d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH)) && !flush;
        do_pop  = pop && (q.cnt != '0) && !flush;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = wdata;
                d.wp        = step(q.wp);
            end
            if (do_pop) d.rp = step(q.rp);
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign count = q.cnt;

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CW'(DEPTH) && push && !pop && !flush) |=> (q.cnt == CW'(DEPTH)));
    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && pop && !push) |=> (q.cnt == '0 && $stable(q.rp)));
endmodule

// File: rtl/trng_crst_timer.sv
module trng_crst_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } tst_t;

    tst_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;

    // R9
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.done);
    // R9
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != '0) |=> q.busy);
endmodule

// File: rtl/trng_regfront.sv
module trng_regfront
    import trng_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int FIFO_DEPTH  = 4,
    parameter int CRST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ent_valid,
    input  logic [31:0]       ent_word,
    input  logic              seed_fault,
    input  logic              seed_recover,
    input  logic              clk_fault,
    output logic              irq
);
    localparam int REG_W = 32;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    regs_t q, d;

    logic             hit_ctrl, hit_stat, hit_data;
    logic             wr_ctrl, wr_stat, rd_data;
    logic             crst_busy, crst_done, crst_start, crst_active;
    logic             seed_hit, fifo_push;
    logic [REG_W-1:0] fifo_head, ctrl_word, stat_word;
    logic [CNT_W-1:0] fifo_cnt;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));
    assign wr_ctrl  = bus_sel && bus_wr && hit_ctrl;
    assign wr_stat  = bus_sel && bus_wr && hit_stat;
    assign rd_data  = bus_sel && !bus_wr && hit_data;

    assign crst_active = q.crst_req || crst_busy;
    assign crst_start  = wr_ctrl && q.crst_req && !bus_wdata[CB_CRST];
    assign seed_hit    = seed_fault && q.gen_en;
    assign fifo_push   = ent_valid && q.gen_en && !q.sd_live && !seed_hit && !crst_active;

    trng_wfifo #(.DW(REG_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (crst_active),
        .push  (fifo_push),
        .wdata (ent_word),
        .pop   (rd_data),
        .head  (fifo_head),
        .count (fifo_cnt)
    );

    trng_crst_timer #(.CYCLES(CRST_CYCLES)) i_crst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crst_start),
        .busy  (crst_busy),
        .done  (crst_done)
    );

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.gen_en   = bus_wdata[CB_GEN];
            d.irq_en   = bus_wdata[CB_IRQEN];
            d.ck_mask  = bus_wdata[CB_CKMASK];
            d.div_exp  = bus_wdata[CB_DIV_LO +: DIV_W];
            d.crst_req = bus_wdata[CB_CRST];
        end
        if (wr_stat) begin
            d.sd_lat = q.sd_lat && bus_wdata[SB_SDLAT];
            d.ck_lat = q.ck_lat && bus_wdata[SB_CKLAT];
        end
        if (seed_hit) begin
            d.sd_live = 1'b1;
            d.sd_lat  = 1'b1;
        end else if (seed_recover || crst_done) begin
            d.sd_live = 1'b0;
        end
        d.ck_live = clk_fault && !q.ck_mask;
        if (d.ck_live) d.ck_lat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CB_GEN]                = q.gen_en;
        ctrl_word[CB_IRQEN]              = q.irq_en;
        ctrl_word[CB_CKMASK]             = q.ck_mask;
        ctrl_word[CB_DIV_LO +: DIV_W]    = q.div_exp;
        ctrl_word[CB_CRST]               = crst_active;
        stat_word                        = '0;
        stat_word[SB_READY]              = (fifo_cnt != '0);
        stat_word[SB_CKLIVE]             = q.ck_live;
        stat_word[SB_SDLIVE]             = q.sd_live;
        stat_word[SB_CKLAT]              = q.ck_lat;
        stat_word[SB_SDLAT]              = q.sd_lat;
        bus_rdata                        = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_ctrl)      bus_rdata = ctrl_word;
            else if (hit_stat) bus_rdata = stat_word;
            else if (hit_data && fifo_cnt != '0) bus_rdata = fifo_head;
        end
    end

    assign irq = q.irq_en && (q.sd_lat || q.ck_lat);

    // R5
    seed_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_fault && q.gen_en) |=> (q.sd_live && q.sd_lat));
    // R2
    halt_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sd_live |=> (fifo_cnt <= $past(fifo_cnt)));
    // R7
    lat_write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[SB_SDLAT] && q.sd_lat) |=> q.sd_lat);
    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> q.irq_en);
    // R9
    crst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_active && $past(crst_active)) |-> (fifo_cnt == '0));
endmodule

// File: tb/test_trng_regfront.sv
`timescale 1ns/1ps
module test_trng_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ent_valid = 1'b0;
    logic [31:0] ent_word = '0;
    logic        seed_fault = 1'b0, seed_recover = 1'b0, clk_fault = 1'b0;
    logic        irq;

    int vecs = 0;
    int bad  = 0;

    always #2 clk = ~clk;

    trng_regfront i_trng_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_valid(ent_valid), .ent_word(ent_word), .seed_fault(seed_fault),
        .seed_recover(seed_recover), .clk_fault(clk_fault), .irq(irq)
    );

    localparam logic [3:0] OP_IDLE = 4'd0, OP_WR = 4'd1, OP_RD = 4'd2, OP_PUSH = 4'd3,
                           OP_RDPUSH = 4'd4, OP_SEED = 4'd5, OP_RECOV = 4'd6,
                           OP_FON = 4'd7, OP_FOFF = 4'd8, OP_IRQ = 4'd9;
    localparam logic [3:0] A_C = 4'h0, A_S = 4'h4, A_D = 4'h8;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,   A_C, 32'h0,          32'h0,          8'd1},  // R1
        '{OP_RD,   A_S, 32'h0,          32'h0,          8'd1},  // R1
        '{OP_RD,   A_D, 32'h0,          32'h0,          8'd4},  // R4 empty
        '{OP_WR,   A_C, 32'hBFFF_FFFF,  32'h0,          8'd1},
        '{OP_RD,   A_C, 32'h0,          32'h000F_002C,  8'd1},  // R1 fields
        '{OP_WR,   A_C, 32'h0000_0004,  32'h0,          8'd1},
        '{OP_PUSH, A_C, 32'hA000_0001,  32'h0,          8'd2},
        '{OP_PUSH, A_C, 32'hA000_0002,  32'h0,          8'd2},
        '{OP_RD,   A_S, 32'h0,          32'h0000_0001,  8'd4},  // R4 ready
        '{OP_RD,   A_D, 32'h0,          32'hA000_0001,  8'd3},  // R3 order
        '{OP_RD,   A_D, 32'h0,          32'hA000_0002,  8'd3},
        '{OP_RD,   A_S, 32'h0,          32'h0,          8'd4},
        '{OP_PUSH, A_C, 32'hB000_0001,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hB000_0002,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hB000_0003,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hB000_0004,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hB000_0005,  32'h0,          8'd3},  // R3 dropped
        '{OP_RD,   A_D, 32'h0,          32'hB000_0001,  8'd3},
        '{OP_RD,   A_D, 32'h0,          32'hB000_0002,  8'd3},
        '{OP_RD,   A_D, 32'h0,          32'hB000_0003,  8'd3},
        '{OP_RD,   A_D, 32'h0,          32'hB000_0004,  8'd3},
        '{OP_RD,   A_D, 32'h0,          32'h0,          8'd3},
        '{OP_WR,   A_C, 32'h0,          32'h0,          8'd2},
        '{OP_PUSH, A_C, 32'hC000_0001,  32'h0,          8'd2},
        '{OP_RD,   A_S, 32'h0,          32'h0,          8'd2},  // R2 disabled
        '{OP_WR,   A_C, 32'h0000_0004,  32'h0,          8'd5},
        '{OP_PUSH, A_C, 32'hD000_0001,  32'h0,          8'd5},
        '{OP_SEED, A_C, 32'h0,          32'h0,          8'd5},
        '{OP_RD,   A_S, 32'h0,          32'h0000_0045,  8'd5},  // R5
        '{OP_PUSH, A_C, 32'hD000_0002,  32'h0,          8'd2},  // R2 halted
        '{OP_RD,   A_D, 32'h0,          32'hD000_0001,  8'd2},
        '{OP_RD,   A_D, 32'h0,          32'h0,          8'd2},
        '{OP_IRQ,  A_C, 32'h0,          32'h0,          8'd10}, // R10 disabled
        '{OP_WR,   A_C, 32'h0000_000C,  32'h0,          8'd10},
        '{OP_IRQ,  A_C, 32'h0,          32'h1,          8'd10},
        '{OP_WR,   A_S, 32'hFFFF_FFFF,  32'h0,          8'd7},
        '{OP_RD,   A_S, 32'h0,          32'h0000_0044,  8'd7},  // R7 write-1
        '{OP_RECOV,A_C, 32'h0,          32'h0,          8'd6},
        '{OP_RD,   A_S, 32'h0,          32'h0000_0040,  8'd6},  // R6
        '{OP_WR,   A_S, 32'h0,          32'h0,          8'd7},
        '{OP_RD,   A_S, 32'h0,          32'h0,          8'd7},  // R7 write-0
        '{OP_IRQ,  A_C, 32'h0,          32'h0,          8'd10},
        '{OP_FON,  A_C, 32'h0,          32'h0,          8'd8},
        '{OP_RD,   A_S, 32'h0,          32'h0000_0022,  8'd8},  // R8
        '{OP_FOFF, A_C, 32'h0,          32'h0,          8'd8},
        '{OP_RD,   A_S, 32'h0,          32'h0000_0020,  8'd8},
        '{OP_IRQ,  A_C, 32'h0,          32'h1,          8'd10},
        '{OP_WR,   A_S, 32'h0,          32'h0,          8'd8},
        '{OP_WR,   A_C, 32'h0000_002C,  32'h0,          8'd8},
        '{OP_FON,  A_C, 32'h0,          32'h0,          8'd8},
        '{OP_RD,   A_S, 32'h0,          32'h0,          8'd8},  // R8 masked
        '{OP_FOFF, A_C, 32'h0,          32'h0,          8'd8},
        '{OP_PUSH, A_C, 32'hE000_0001,  32'h0,          8'd11},
        '{OP_RDPUSH,A_D,32'hE000_0002,  32'hE000_0001,  8'd11}, // R11
        '{OP_RD,   A_D, 32'h0,          32'hE000_0002,  8'd11},
        '{OP_RD,   A_D, 32'h0,          32'h0,          8'd11},
        '{OP_PUSH, A_C, 32'hF000_0001,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hF000_0002,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hF000_0003,  32'h0,          8'd3},
        '{OP_PUSH, A_C, 32'hF000_0004,  32'h0,          8'd3}
    };

    task automatic run_op(input vec_t v);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = v.addr; bus_wdata = '0;
        ent_valid = 1'b0; ent_word = '0; seed_fault = 1'b0; seed_recover = 1'b0;
        case (v.op)
            OP_WR:     begin bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v.data; end
            OP_RD:     bus_sel = 1'b1;
            OP_PUSH:   begin ent_valid = 1'b1; ent_word = v.data; end
            OP_RDPUSH: begin bus_sel = 1'b1; ent_valid = 1'b1; ent_word = v.data; end
            OP_SEED:   seed_fault = 1'b1;
            OP_RECOV:  seed_recover = 1'b1;
            OP_FON:    clk_fault = 1'b1;
            OP_FOFF:   clk_fault = 1'b0;
            default:   ;
        endcase
        #1;
        if (v.op == OP_RD || v.op == OP_RDPUSH) begin
            vecs++;
            if (bus_rdata !== v.exp) begin
                bad++;
                $display("FAIL R%0d: addr %h read %h expected %h", v.req, v.addr, bus_rdata, v.exp);
            end
        end else if (v.op == OP_IRQ) begin
            vecs++;
            if (irq !== v.exp[0]) begin
                bad++;
                $display("FAIL R%0d: irq %b expected %b", v.req, irq, v.exp[0]);
            end
        end
        @(posedge clk);
    endtask

    function automatic vec_t mk(input logic [3:0] op, input logic [3:0] a,
                                input logic [31:0] dt, input logic [31:0] e,
                                input logic [7:0] r);
        return '{op, a, dt, e, r};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        vecs++;
        if (irq !== 1'b0 || bus_rdata !== 32'h0) begin
            bad++;
            $display("FAIL R1: reset irq %b rdata %h expected 0 0", irq, bus_rdata);
        end
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_op(VECS[i]);
        // R3: full queue, read and offer in same cycle -> offer lost
        run_op(mk(OP_RDPUSH, A_D, 32'hF000_0005, 32'hF000_0001, 8'd3));
        run_op(mk(OP_RD, A_D, 32'h0, 32'hF000_0002, 8'd3));
        run_op(mk(OP_RD, A_D, 32'h0, 32'hF000_0003, 8'd3));
        run_op(mk(OP_RD, A_D, 32'h0, 32'hF000_0004, 8'd3));
        run_op(mk(OP_RD, A_D, 32'h0, 32'h0, 8'd3));
        // R9: conditioning reset sequence
        run_op(mk(OP_WR, A_C, 32'h0000_0004, 32'h0, 8'd9));
        run_op(mk(OP_PUSH, A_C, 32'h9000_0001, 32'h0, 8'd9));
        run_op(mk(OP_SEED, A_C, 32'h0, 32'h0, 8'd9));
        run_op(mk(OP_WR, A_C, 32'h4000_0004, 32'h0, 8'd9));
        run_op(mk(OP_PUSH, A_C, 32'h9000_0002, 32'h0, 8'd9));
        run_op(mk(OP_RD, A_C, 32'h0, 32'h4000_0004, 8'd9));
        run_op(mk(OP_RD, A_S, 32'h0, 32'h0000_0044, 8'd9));
        run_op(mk(OP_WR, A_C, 32'h0000_0004, 32'h0, 8'd9));
        for (int k = 0; k < 15; k++)
            run_op(mk(OP_RD, A_C, 32'h0, 32'h4000_0004, 8'd9));
        run_op(mk(OP_RD, A_S, 32'h0, 32'h0000_0044, 8'd9));
        run_op(mk(OP_RD, A_C, 32'h0, 32'h0000_0004, 8'd9));
        run_op(mk(OP_RD, A_S, 32'h0, 32'h0000_0040, 8'd9));
        run_op(mk(OP_RD, A_D, 32'h0, 32'h0, 8'd9));
        run_op(mk(OP_PUSH, A_C, 32'h9000_0003, 32'h0, 8'd9));
        run_op(mk(OP_RD, A_D, 32'h0, 32'h9000_0003, 8'd9));
        run_op(mk(OP_IDLE, A_C, 32'h0, 32'h0, 8'd0));
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule